// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Sequencer

This block turns a single PWM command into two mutually exclusive gate enables for the high-side and low-side switches of a synchronous buck half-bridge. It receives digitised comparator results as inputs. These are a flag that the low gate has fallen below its threshold, a flag that the high gate-to-source voltage has fallen below its threshold, a flag that the switch node is low, a power-good level that already has hysteresis, and a flag that the PWM input sits in its mid-level window. Every input passes through a synchroniser before the controller uses it.

Dead time adapts to the switches that are fitted. A gate is enabled only after the opposite gate is sensed off. On the high-side turn-on, a blanking window masks the low-gate flag for a set time. On the low-side turn-on, a timeout path takes over when the switch-node flag never arrives. If the PWM input stays in its mid-level window for a holdoff interval, both enables are forced low and a shutdown status is raised. When PWM leaves the window, normal sequencing resumes and follows the PWM level present at that time.

All latencies below are counted in clock edges from the edge after an input changes. `S` is the synchroniser depth (default 2). BLANK, TMO and HOLD are the parameters `BLANK_CYC`, `TMO_CYC` and `HOLD_CYC`.

Top module: `gate_sequencer`

## Requirements
- R1: While power-good is low, both enables are low within S+1 cycles and PWM changes have no effect on them. When power-good returns, the enable chosen follows the PWM level.
- R2: `hs_en_o` and `ls_en_o` are never high in the same cycle, including during reset.
- R3: A rising PWM level drops `ls_en_o` S+1 cycles later, while `hs_en_o` is still low.
- R4: With the low-gate flag already high, `hs_en_o` rises exactly S+2+BLANK cycles after the PWM rise, because the flag is ignored for BLANK cycles after the low-side turn-off starts.
- R5: `hs_en_o` stays low while the low-gate flag is low. It rises S+1 cycles after the flag goes high, once blanking has expired.
- R6: A falling PWM level drops `hs_en_o` S+1 cycles later, while `ls_en_o` is still low.
- R7: With the switch-node-low flag high, `ls_en_o` rises S+2 cycles after the PWM fall.
- R8: Without the switch-node flag, `ls_en_o` stays low until the high-gate-source flag is high. It then rises S+1+TMO cycles after that flag rises.
- R9: A mid-level window flag held for HOLD cycles raises `shut_o` S+1+HOLD cycles after it asserts, with both enables low. A window shorter than HOLD cycles changes nothing.
- R10: `shut_o` clears S+1 cycles after the window flag drops. The next gate enabled is the one that matches the PWM level present at that time (a high level enables the high side).
- R11: A PWM edge that arrives during an unfinished transition cancels that transition. The opposite sequence then restarts, and the cancelled enable never rises.
- R12: During reset and immediately after it, `hs_en_o`, `ls_en_o` and `shut_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_i | input | 1 | PWM command level (1 = high side on) |
| pwm_mid_i | input | 1 | PWM sits in the mid-level window |
| lg_low_i | input | 1 | Low gate is below its threshold |
| hgs_low_i | input | 1 | High gate-to-source voltage is below its threshold |
| sw_low_i | input | 1 | Switch node is below its low threshold |
| pwr_ok_i | input | 1 | Supply good, with hysteresis already applied |
| hs_en_o | output | 1 | High-side gate enable |
| ls_en_o | output | 1 | Low-side gate enable |
| shut_o | output | 1 | Mid-level shutdown is active |

## Verification
The bench builds the block with BLANK=3, TMO=5 and HOLD=6. These values are short enough that each fixed window can be measured edge by edge, while the values still differ from one another. With them, a mid-level pulse one cycle shorter than the holdoff, and a cancelling edge that lands while the opposite switch is still waiting on its sense flag, both fit into a few dozen cycles. A random phase then toggles every flag thousands of times. This reaches overlapping blanking, timeout and holdoff windows that the directed cases do not.

// File: rtl/gs_pkg.sv
package gs_pkg;
  typedef enum logic [2:0] {
    ST_OFF     = 3'd0,
    ST_HS_WAIT = 3'd1,
    ST_HS_ON   = 3'd2,
    ST_LS_WAIT = 3'd3,
    ST_LS_ON   = 3'd4,
    ST_SHUT    = 3'd5
  } gs_state_t;

  localparam int GS_NUM_IN = 6;
  localparam int GS_B_PWM  = 0;
  localparam int GS_B_MID  = 1;
  localparam int GS_B_LG   = 2;
  localparam int GS_B_HGS  = 3;
  localparam int GS_B_SW   = 4;
  localparam int GS_B_OK   = 5;
endpackage

// File: rtl/gs_sync.sv
module gs_sync #(
  parameter int WIDTH  = 6,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/gs_timer.sv
module gs_timer #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  output logic done_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr_i)   cnt <= '0;
    else if (cnt != LIM) cnt <= cnt + 1'b1;
  end

  assign done_o = (cnt == LIM);
endmodule

// File: rtl/gs_fsm.sv
module gs_fsm
  import gs_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      s_pwm_i,
  input  logic      s_mid_i,
  input  logic      s_lg_i,
  input  logic      s_hgs_i,
  input  logic      s_sw_i,
  input  logic      s_ok_i,
  input  logic      blank_done_i,
  input  logic      tmo_done_i,
  input  logic      hold_done_i,
  output gs_state_t state_o,
  output logic      hs_en_o,
  output logic      ls_en_o,
  output logic      shut_o
);
  gs_state_t state, state_n;
  logic      cmd_q, cmd;

  // Inside the mid window the PWM level is not trusted; keep the last one.
  assign cmd = s_mid_i ? cmd_q : s_pwm_i;

  always_comb begin
    state_n = state;
    if (!s_ok_i) begin
      state_n = ST_OFF;
    end else if (hold_done_i && s_mid_i) begin
      state_n = ST_SHUT;
    end else begin
      unique case (state)
        ST_OFF, ST_SHUT: begin
          if (!s_mid_i) state_n = s_pwm_i ? ST_HS_WAIT : ST_LS_WAIT;
        end
        ST_HS_WAIT: begin
          if (!cmd)                           state_n = ST_LS_WAIT;
          else if (blank_done_i && s_lg_i)    state_n = ST_HS_ON;
        end
        ST_HS_ON: begin
          if (!cmd) state_n = ST_LS_WAIT;
        end
        ST_LS_WAIT: begin
          if (cmd)                            state_n = ST_HS_WAIT;
          else if (s_sw_i || tmo_done_i)      state_n = ST_LS_ON;
        end
        ST_LS_ON: begin
          if (cmd) state_n = ST_HS_WAIT;
        end
        default: state_n = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_OFF;
      cmd_q   <= 1'b0;
      hs_en_o <= 1'b0;
      ls_en_o <= 1'b0;
      shut_o  <= 1'b0;
    end else begin
      state   <= state_n;
      cmd_q   <= cmd;
      hs_en_o <= (state_n == ST_HS_ON);
      ls_en_o <= (state_n == ST_LS_ON);
      shut_o  <= (state_n == ST_SHUT);
    end
  end

  assign state_o = state;

  AST_NO_OVERLAP: assert property (@(posedge clk) !(hs_en_o && ls_en_o)); // R2

  AST_OFF_NO_POWER: assert property (@(posedge clk) disable iff (rst)
    !s_ok_i |=> (!hs_en_o && !ls_en_o)); // R1

  AST_SHUT_GATES_LOW: assert property (@(posedge clk) disable iff (rst)
    shut_o |-> (!hs_en_o && !ls_en_o)); // R9

  AST_HS_AFTER_LG: assert property (@(posedge clk) disable iff (rst)
    $rose(hs_en_o) |-> $past(s_lg_i && blank_done_i)); // R5

  AST_LS_AFTER_SENSE: assert property (@(posedge clk) disable iff (rst)
    $rose(ls_en_o) |-> $past(s_sw_i || tmo_done_i)); // R8

  AST_HS_DROP_ON_LOW: assert property (@(posedge clk) disable iff (rst)
    (hs_en_o && !cmd) |=> !hs_en_o); // R6
endmodule

// File: rtl/gate_sequencer.sv
module gate_sequencer
  import gs_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BLANK_CYC   = 5,
  parameter int TMO_CYC     = 8,
  parameter int HOLD_CYC    = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic pwm_i,
  input  logic pwm_mid_i,
  input  logic lg_low_i,
  input  logic hgs_low_i,
  input  logic sw_low_i,
  input  logic pwr_ok_i,
  output logic hs_en_o,
  output logic ls_en_o,
  output logic shut_o
);
  logic [GS_NUM_IN-1:0] raw, syn;
  gs_state_t            state;
  logic                 blank_done, tmo_done, hold_done;

  assign raw[GS_B_PWM] = pwm_i;
  assign raw[GS_B_MID] = pwm_mid_i;
  assign raw[GS_B_LG]  = lg_low_i;
  assign raw[GS_B_HGS] = hgs_low_i;
  assign raw[GS_B_SW]  = sw_low_i;
  assign raw[GS_B_OK]  = pwr_ok_i;

  gs_sync #(.WIDTH(GS_NUM_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk), .rst (rst), .d_i (raw), .q_o (syn)
  );

  // Blanking runs from entry into the high-side wait.
  gs_timer #(.LIMIT(BLANK_CYC)) u_blank (
    .clk (clk), .rst (rst),
    .clr_i (state != ST_HS_WAIT),
    .done_o (blank_done)
  );

  // Timeout runs while waiting for the low side with the high gate sensed off.
  gs_timer #(.LIMIT(TMO_CYC)) u_tmo (
    .clk (clk), .rst (rst),
    .clr_i ((state != ST_LS_WAIT) || !syn[GS_B_HGS]),
    .done_o (tmo_done)
  );

  // Holdoff runs while PWM stays inside the mid window.
  gs_timer #(.LIMIT(HOLD_CYC)) u_hold (
    .clk (clk), .rst (rst),
    .clr_i (!syn[GS_B_MID]),
    .done_o (hold_done)
  );

  gs_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .s_pwm_i      (syn[GS_B_PWM]),
    .s_mid_i      (syn[GS_B_MID]),
    .s_lg_i       (syn[GS_B_LG]),
    .s_hgs_i      (syn[GS_B_HGS]),
    .s_sw_i       (syn[GS_B_SW]),
    .s_ok_i       (syn[GS_B_OK]),
    .blank_done_i (blank_done),
    .tmo_done_i   (tmo_done),
    .hold_done_i  (hold_done),
    .state_o      (state),
    .hs_en_o      (hs_en_o),
    .ls_en_o      (ls_en_o),
    .shut_o       (shut_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!hs_en_o && !ls_en_o && !shut_o)); // R12
endmodule

// File: tb/gate_sequencer_test.sv
module gate_sequencer_test;
  localparam int CLK_PERIOD = 10;
  localparam int S     = 2;
  localparam int BLANK = 3;
  localparam int TMO   = 5;
  localparam int HOLD  = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwm = 1'b0, mid = 1'b0, lg = 1'b1, hgs = 1'b1, sw = 1'b1, ok = 1'b1;
  logic hs, ls, shut;
  int   n_chk = 0, n_fail = 0;
  bit   finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gate_sequencer #(.SYNC_STAGES(S), .BLANK_CYC(BLANK), .TMO_CYC(TMO),
                   .HOLD_CYC(HOLD)) uut (
    .clk (clk), .rst (rst), .pwm_i (pwm), .pwm_mid_i (mid), .lg_low_i (lg),
    .hgs_low_i (hgs), .sw_low_i (sw), .pwr_ok_i (ok),
    .hs_en_o (hs), .ls_en_o (ls), .shut_o (shut)
  );

  function automatic int lat_sense(); return S + 1; endfunction
  function automatic int lat_hs_blank(); return S + 2 + BLANK; endfunction
  function automatic int lat_ls_sw(); return S + 2; endfunction
  function automatic int lat_ls_tmo(); return S + 1 + TMO; endfunction
  function automatic int lat_shut(); return S + 1 + HOLD; endfunction

  function automatic logic sig(input int sel);
    case (sel)
      0: return hs;
      1: return ls;
      default: return shut;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Counts negedges until the selected output reaches val; maxc+1 if never.
  task automatic measure(input int sel, input logic val, input int maxc, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (sig(sel) != val && n <= maxc);
  endtask

  // Watches an output for n cycles; returns 1 if it ever took value val.
  task automatic watch(input int sel, input logic val, input int n, output bit seen);
    seen = 1'b0;
    repeat (n) begin
      @(negedge clk);
      if (sig(sel) == val) seen = 1'b1;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int  n;
    bit  seen;
    int  ok_low_run;
    void'($urandom(32'h5eed_1234));

    // R12 reset state
    step(4);
    check("R12 hs in reset", hs, 0);
    check("R12 ls in reset", ls, 0);
    check("R12 shut in reset", shut, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R12 hs after reset", hs, 0);
    check("R12 shut after reset", shut, 0);
    step(10);
    check("R1 low side on after power-good with pwm low", ls, 1);

    // R3 and R4: rising edge with low-gate flag already high
    pwm = 1'b1;
    measure(1, 1'b0, 20, n);
    check("R3 ls drop latency", n, lat_sense());
    check("R3 hs still low at ls drop", hs, 0);
    measure(0, 1'b1, 20, n);
    check("R4 hs rise latency with blanking", n + lat_sense(), lat_hs_blank());

    // R6 and R7: falling edge with switch-node flag high
    pwm = 1'b0;
    measure(0, 1'b0, 20, n);
    check("R6 hs drop latency", n, lat_sense());
    check("R6 ls still low at hs drop", ls, 0);
    measure(1, 1'b1, 20, n);
    check("R7 ls rise latency", n + lat_sense(), lat_ls_sw());

    // R5: high side waits on the low-gate flag
    lg = 1'b0;
    pwm = 1'b1;
    measure(1, 1'b0, 20, n);
    watch(0, 1'b1, 20, seen);
    check("R5 hs held off without lg flag", seen, 0);
    lg = 1'b1;
    measure(0, 1'b1, 20, n);
    check("R5 hs latency after lg flag", n, lat_sense());

    // R8: timeout path without switch-node flag
    sw = 1'b0;
    hgs = 1'b0;
    pwm = 1'b0;
    measure(0, 1'b0, 20, n);
    watch(1, 1'b1, 20, seen);
    check("R8 ls held off without any sense flag", seen, 0);
    hgs = 1'b1;
    measure(1, 1'b1, 30, n);
    check("R8 ls latency via timeout", n, lat_ls_tmo());
    sw = 1'b1;

    // R9: short window is ignored
    mid = 1'b1;
    step(HOLD - 1);
    mid = 1'b0;
    watch(2, 1'b1, 12, seen);
    check("R9 short window no shutdown", seen, 0);
    check("R9 ls kept after short window", ls, 1);

    // R9: full window shuts down
    mid = 1'b1;
    measure(2, 1'b1, 30, n);
    check("R9 shutdown latency", n, lat_shut());
    check("R9 hs low in shutdown", hs, 0);
    check("R9 ls low in shutdown", ls, 0);
    pwm = 1'b1;
    step(5);
    check("R9 shutdown holds", shut, 1);

    // R10: exit follows pwm level (high -> high side)
    mid = 1'b0;
    measure(2, 1'b0, 20, n);
    check("R10 shutdown clear latency", n, lat_sense());
    measure(0, 1'b1, 20, n);
    check("R10 hs chosen after exit", n + lat_sense(), lat_hs_blank());
    check("R10 ls low after exit", ls, 0);

    // R11: cancel a pending low-side turn-on
    sw = 1'b0;
    hgs = 1'b0;
    pwm = 1'b0;
    measure(0, 1'b0, 20, n);
    step(2);
    pwm = 1'b1;
    seen = 1'b0;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (ls) seen = 1'b1;
    end while (!hs && n <= 30);
    check("R11 ls never glitched on cancel", seen, 0);
    check("R11 hs restart latency", n, lat_hs_blank());
    sw = 1'b1;
    hgs = 1'b1;

    // R11: cancel a pending high-side turn-on
    pwm = 1'b0;
    measure(1, 1'b1, 20, n);
    lg = 1'b0;
    pwm = 1'b1;
    measure(1, 1'b0, 20, n);
    step(2);
    pwm = 1'b0;
    seen = 1'b0;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (hs) seen = 1'b1;
    end while (!ls && n <= 30);
    check("R11 hs never glitched on cancel", seen, 0);
    check("R11 ls restart latency", n, lat_ls_sw());
    lg = 1'b1;

    // R1: power-good low ignores pwm
    ok = 1'b0;
    measure(1, 1'b0, 20, n);
    check("R1 enables off latency", n, lat_sense());
    seen = 1'b0;
    for (int i = 0; i < 20; i++) begin
      pwm = i[1];
      @(negedge clk);
      if (hs || ls) seen = 1'b1;
    end
    check("R1 pwm ignored without power", seen, 0);
    pwm = 1'b1;
    ok = 1'b1;
    measure(0, 1'b1, 30, n);
    check("R1 resume follows pwm high", n, lat_hs_blank());

    // Random phase: R2 and R9 and R1 invariants
    ok_low_run = 0;
    for (int c = 0; c < 4000; c++) begin
      if (($urandom % 8) == 0) pwm = ~pwm;
      if (($urandom % 40) == 0) mid = ~mid;
      lg  = ($urandom % 4) != 0;
      hgs = ($urandom % 3) != 0;
      sw  = ($urandom % 5) == 0;
      if (($urandom % 200) == 0) ok = ~ok;
      @(negedge clk);
      ok_low_run = ok ? 0 : ok_low_run + 1;
      check("R2 no overlap", (hs && ls), 0);
      if (shut) check("R9 shutdown gates low", (hs || ls), 0);
      if (ok_low_run > lat_sense()) check("R1 no gate without power", (hs || ls), 0);
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule